// File: doc/BRIEF.md
# Replicated-State Multiport Register File

This block is a small register file that offers four read ports and two write ports, all with fixed timing. It never stalls. No cell carries all four read ports. The storage is instead held in two identical copies. Read ports 0 and 1 are served by copy 0, and read ports 2 and 3 by copy 1. Each write is broadcast to every copy in the same cycle, so the copies never diverge.

Reads are combinational from the stored state. A write is taken at the rising clock edge. Its data appears on every read port from that edge onward, and there is no bypass within the cycle of the write. When both write ports target the same entry in one cycle, write port 1 wins. Entry 0 is an ordinary register with no special meaning.

Top module: `repl_regfile`

## Requirements
- R1: A clock edge that samples rst_n low clears every entry to zero, as seen on all four read ports.
- R2: A write on port 0 (wp0_en high) stores wp0_data into entry wp0_addr at the clock edge, and the value is returned on all four read ports after that edge.
- R3: A write on port 1 (wp1_en high) stores wp1_data into entry wp1_addr at the clock edge, and the value is returned on all four read ports after that edge.
- R4: When both write ports are enabled with the same address in one cycle, the entry holds wp1_data after the edge.
- R5: When both write ports are enabled with different addresses in one cycle, both entries are updated at the same edge.
- R6: No same-cycle bypass: in the cycle in which a write is presented, a read port that addresses the same entry still returns the old value.
- R7: A write port whose enable is low changes no entry, whatever its address and data are.
- R8: Read port p returns the entry selected by bits [p*4+3:p*4] of rp_addr on bits [p*32+31:p*32] of rp_data, within the same cycle. Any two ports that address the same entry return equal data, whichever copy serves them.
- R9: Entry 0 can be written and read back like any other entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wp0_en | input | 1 | Write port 0 enable |
| wp0_addr | input | 4 | Write port 0 entry index |
| wp0_data | input | 32 | Write port 0 data |
| wp1_en | input | 1 | Write port 1 enable (wins a same-entry collision) |
| wp1_addr | input | 4 | Write port 1 entry index |
| wp1_data | input | 32 | Write port 1 data |
| rp_addr | input | 16 | Four packed 4-bit read indices, port 0 in the low bits |
| rp_data | output | 128 | Four packed 32-bit read results, port 0 in the low bits |

## Verification
The assertions assume that the inputs are never unknown once reset is released. They also take ENTRIES as a power of two, so every read index names a real entry. The visibility properties look one cycle back and assume that the read index of the checked port holds the written address in the following cycle. When it does not, they pass vacuously. The bench drives every input at the falling edge and holds the write enables low between write tasks. It sweeps every address on every port with rotated offsets, so that the two copies are compared against each other on different entries at once.

// File: rtl/rf_pkg.sv
// Package: shared types for the replicated register file.
// Assumes: nothing beyond standard SystemVerilog.
package rf_pkg;
    // Per-entry write source chosen by the collision resolver.
    typedef enum logic [1:0] {
        WSEL_NONE = 2'd0,
        WSEL_P0   = 2'd1,
        WSEL_P1   = 2'd2
    } wsel_e;
endpackage

// File: rtl/rf_wr_resolve.sv
// Module: rf_wr_resolve
// Turns the two write ports into one source select per entry. Port 1
// wins when both ports address the same entry. The result is shared by
// every copy, so all copies take identical updates.
// Assumes: ENTRIES <= 2**ABITS.
module rf_wr_resolve
    import rf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ABITS   = 4
) (
    input  logic             wp0_en,
    input  logic [ABITS-1:0] wp0_addr,
    input  logic             wp1_en,
    input  logic [ABITS-1:0] wp1_addr,
    output wsel_e            sel [ENTRIES]
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic hit0;
        logic hit1;
        assign hit0 = wp0_en && (wp0_addr == ABITS'(e));
        assign hit1 = wp1_en && (wp1_addr == ABITS'(e));

        // Pick the source for this entry, giving port 1 priority.
        always_comb begin
            if (hit1)      sel[e] = WSEL_P1;
            else if (hit0) sel[e] = WSEL_P0;
            else           sel[e] = WSEL_NONE;
        end
    end
endmodule

// File: rtl/rf_copy.sv
// Module: rf_copy
// One replica of the register state. It takes every write through the
// shared selects and serves its own group of read ports combinationally.
// Assumes: ENTRIES is a power of two equal to 2**ABITS, so every read
// index names a real entry.
module rf_copy
    import rf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int ABITS   = 4,
    parameter int NRD     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  wsel_e                  sel [ENTRIES],
    input  logic [WIDTH-1:0]       wd0,
    input  logic [WIDTH-1:0]       wd1,
    input  logic [NRD*ABITS-1:0]   rd_addr,
    output logic [NRD*WIDTH-1:0]   rd_data
);
    logic [WIDTH-1:0] mem [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        // Update one entry from its selected write source, or clear it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else begin
                case (sel[e])
                    WSEL_P0: mem[e] <= wd0;
                    WSEL_P1: mem[e] <= wd1;
                    default: ;
                endcase
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        // Read port r: combinational select from this copy.
        assign rd_data[r*WIDTH +: WIDTH] = mem[rd_addr[r*ABITS +: ABITS]];
    end
endmodule

// File: rtl/repl_regfile.sv
// Module: repl_regfile (top)
// Two write ports and NUM_COPIES*READS_PER_COPY read ports over
// replicated storage. Read port p is served by copy p / READS_PER_COPY.
// Writes are broadcast to all copies and take effect at the rising edge.
// Assumes: ENTRIES == 2**$clog2(ENTRIES); inputs known after reset.
module repl_regfile #(
    parameter int ENTRIES        = 16,
    parameter int WIDTH          = 32,
    parameter int NUM_COPIES     = 2,
    parameter int READS_PER_COPY = 2,
    localparam int ABITS         = $clog2(ENTRIES),
    localparam int NUM_RD        = NUM_COPIES * READS_PER_COPY
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wp0_en,
    input  logic [ABITS-1:0]        wp0_addr,
    input  logic [WIDTH-1:0]        wp0_data,
    input  logic                    wp1_en,
    input  logic [ABITS-1:0]        wp1_addr,
    input  logic [WIDTH-1:0]        wp1_data,
    input  logic [NUM_RD*ABITS-1:0] rp_addr,
    output logic [NUM_RD*WIDTH-1:0] rp_data
);
    localparam int GA = READS_PER_COPY * ABITS;
    localparam int GD = READS_PER_COPY * WIDTH;

    rf_pkg::wsel_e sel [ENTRIES];

    rf_wr_resolve #(
        .ENTRIES (ENTRIES),
        .ABITS   (ABITS)
    ) u_resolve (
        .wp0_en   (wp0_en),
        .wp0_addr (wp0_addr),
        .wp1_en   (wp1_en),
        .wp1_addr (wp1_addr),
        .sel      (sel)
    );

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        rf_copy #(
            .ENTRIES (ENTRIES),
            .WIDTH   (WIDTH),
            .ABITS   (ABITS),
            .NRD     (READS_PER_COPY)
        ) u_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .wd0     (wp0_data),
            .wd1     (wp1_data),
            .rd_addr (rp_addr[c*GA +: GA]),
            .rd_data (rp_data[c*GD +: GD])
        );
    end
endmodule

// File: rtl/repl_regfile_chk.sv
// Module: repl_regfile_chk
// Property checker bound to repl_regfile. It watches read port 0 (first
// copy) and the last read port (last copy).
// Assumes: default port grouping, so the two watched ports sit in
// different copies.
module repl_regfile_chk #(
    parameter int WIDTH = 32,
    parameter int ABITS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wp0_en,
    input logic [ABITS-1:0] wp0_addr,
    input logic [WIDTH-1:0] wp0_data,
    input logic             wp1_en,
    input logic [ABITS-1:0] wp1_addr,
    input logic [WIDTH-1:0] wp1_data,
    input logic [ABITS-1:0] ra_first,
    input logic [WIDTH-1:0] rd_first,
    input logic [ABITS-1:0] ra_last,
    input logic [WIDTH-1:0] rd_last
);
    // R2
    p0_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp0_en && !(wp1_en && wp1_addr == wp0_addr))
        |=> (ra_first != $past(wp0_addr) || rd_first == $past(wp0_data)));

    // R3
    p1_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp1_en |=> (ra_last != $past(wp1_addr) || rd_last == $past(wp1_data)));

    // R4
    collide_p1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp0_en && wp1_en && wp0_addr == wp1_addr)
        |=> (ra_first != $past(wp1_addr) || rd_first == $past(wp1_data)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp0_en && !wp1_en)
        |=> (ra_first != $past(ra_first) || rd_first == $past(rd_first)));

    // R8
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_first == ra_last) |-> (rd_first == rd_last));
endmodule

bind repl_regfile repl_regfile_chk #(
    .WIDTH (WIDTH),
    .ABITS (ABITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp0_en   (wp0_en),
    .wp0_addr (wp0_addr),
    .wp0_data (wp0_data),
    .wp1_en   (wp1_en),
    .wp1_addr (wp1_addr),
    .wp1_data (wp1_data),
    .ra_first (rp_addr[ABITS-1:0]),
    .rd_first (rp_data[WIDTH-1:0]),
    .ra_last  (rp_addr[NUM_RD*ABITS-1 -: ABITS]),
    .rd_last  (rp_data[NUM_RD*WIDTH-1 -: WIDTH])
);

// File: tb/repl_regfile_bench.sv
module repl_regfile_bench;
    localparam int ENTRIES = 16;
    localparam int WIDTH   = 32;
    localparam int ABITS   = 4;
    localparam int NUM_RD  = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst_n;
    logic                    wp0_en, wp1_en;
    logic [ABITS-1:0]        wp0_addr, wp1_addr;
    logic [WIDTH-1:0]        wp0_data, wp1_data;
    logic [NUM_RD*ABITS-1:0] rp_addr;
    logic [NUM_RD*WIDTH-1:0] rp_data;

    logic [WIDTH-1:0] model [ENTRIES];
    int checks = 0;
    int fails  = 0;

    repl_regfile u_repl_regfile (
        .clk(clk), .rst_n(rst_n),
        .wp0_en(wp0_en), .wp0_addr(wp0_addr), .wp0_data(wp0_data),
        .wp1_en(wp1_en), .wp1_addr(wp1_addr), .wp1_data(wp1_data),
        .rp_addr(rp_addr), .rp_data(rp_data)
    );

    function automatic logic [WIDTH-1:0] pat(int a, int k);
        return 32'h9E37_79B9 * (a + 1) + 32'h0101_0101 * k;
    endfunction

    task automatic chk(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] rdat(int p);
        return rp_data[p*WIDTH +: WIDTH];
    endfunction

    task automatic set_rd(int p, int a);
        rp_addr[p*ABITS +: ABITS] = ABITS'(a);
    endtask

    // One write cycle: drive at the falling edge, update model at the rising edge.
    task automatic wr(bit e0, int a0, logic [WIDTH-1:0] d0,
                      bit e1, int a1, logic [WIDTH-1:0] d1);
        @(negedge clk);
        wp0_en = e0; wp0_addr = ABITS'(a0); wp0_data = d0;
        wp1_en = e1; wp1_addr = ABITS'(a1); wp1_data = d1;
        @(posedge clk);
        if (e0) model[a0] = d0;
        if (e1) model[a1] = d1;
        @(negedge clk);
        wp0_en = 1'b0; wp1_en = 1'b0;
    endtask

    // Sweep all entries on all ports, each port offset by its index.
    task automatic sweep(string req);
        for (int a = 0; a < ENTRIES; a++) begin
            for (int p = 0; p < NUM_RD; p++) set_rd(p, (a + p) % ENTRIES);
            #1;
            for (int p = 0; p < NUM_RD; p++)
                chk(req, rdat(p), model[(a + p) % ENTRIES]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < ENTRIES; e++) model[e] = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wp0_en = 1'b0; wp1_en = 1'b0;
        wp0_addr = '0; wp1_addr = '0; wp0_data = '0; wp1_data = '0;
        rp_addr = '0;
        for (int e = 0; e < ENTRIES; e++) model[e] = '0;
        do_reset();
        sweep("R1 reset clear");

        // R2: port 0 writes every entry
        for (int e = 0; e < ENTRIES; e++) wr(1, e, pat(e, 1), 0, 0, '0);
        sweep("R2 port0 write");

        // R9: entry 0 is ordinary
        wr(1, 0, 32'hDEAD_BEEF, 0, 0, '0);
        for (int p = 0; p < NUM_RD; p++) set_rd(p, 0);
        #1;
        for (int p = 0; p < NUM_RD; p++) chk("R9 entry0", rdat(p), 32'hDEAD_BEEF);

        // R3: port 1 writes every entry
        for (int e = 0; e < ENTRIES; e++) wr(0, 0, '0, 1, e, pat(e, 2));
        sweep("R3 port1 write");

        // R5: both ports, distinct entries
        for (int e = 0; e < ENTRIES / 2; e++)
            wr(1, e, pat(e, 3), 1, ENTRIES - 1 - e, pat(ENTRIES - 1 - e, 4));
        sweep("R5 dual distinct");

        // R4: both ports, same entry, port 1 wins
        for (int e = 0; e < ENTRIES; e++) wr(1, e, pat(e, 5), 1, e, pat(e, 6));
        for (int e = 0; e < ENTRIES; e++) begin
            set_rd(0, e); #1;
            chk("R4 collision", rdat(0), pat(e, 6));
        end
        sweep("R4 collision sweep");

        // R7: disabled ports change nothing
        for (int e = 0; e < ENTRIES; e++) wr(0, e, 32'hFFFF_FFFF, 0, e, 32'h5555_5555);
        sweep("R7 both disabled");
        wr(0, 7, 32'hFFFF_FFFF, 1, 8, pat(8, 7));
        sweep("R7 port0 disabled");
        wr(1, 9, pat(9, 8), 0, 9, 32'h0BAD_0BAD);
        sweep("R7 port1 disabled");

        // R6: no same-cycle bypass
        for (int e = 0; e < ENTRIES; e += 5) begin
            logic [WIDTH-1:0] old_v;
            old_v = model[e];
            @(negedge clk);
            for (int p = 0; p < NUM_RD; p++) set_rd(p, e);
            wp0_en = 1'b1; wp0_addr = ABITS'(e); wp0_data = pat(e, 9);
            #1;
            for (int p = 0; p < NUM_RD; p++) chk("R6 no bypass", rdat(p), old_v);
            @(posedge clk);
            model[e] = pat(e, 9);
            #1;
            for (int p = 0; p < NUM_RD; p++) chk("R6 after edge", rdat(p), pat(e, 9));
            @(negedge clk);
            wp0_en = 1'b0;
        end

        // R8: four distinct indices at once, across both copies
        for (int a = 0; a < ENTRIES; a++) begin
            for (int p = 0; p < NUM_RD; p++) set_rd(p, (a * 3 + p * 5) % ENTRIES);
            #1;
            for (int p = 0; p < NUM_RD; p++)
                chk("R8 port select", rdat(p), model[(a * 3 + p * 5) % ENTRIES]);
        end

        // R1: reset in mid-run clears everything again
        do_reset();
        sweep("R1 second reset");

        summary();
        $finish;
    end
endmodule